// File: doc/BRIEF.md
# Serial Control Frame Handler

This block drives a serial output stream one word at a time, most significant bit first, and takes in one control word per output word on the input line. A rising edge on the frame sync input opens a frame. The frame carries two sample words (one I/Q pair) or four (two pairs), and a readback word may follow them. Word length can be 16, 24 or 32 bits. The word length, the pair count and the forced-append setting are all latched when the frame opens.

Each incoming control word is decoded from its first 16 bits only. The decode gives a read, a write or no operation on an external port of eight 8-bit registers. Read results are packed into the readback word. That word is sent when the frame held a read, or in every frame when forced append is on. A one-cycle strobe marks the end of each frame. Users of the block can therefore change register contents, or sample them, while the serial stream keeps running.

Top module: `ser_ctrl_frame`

## Requirements
- R1: After the clock edge that sees `fsync` rise, the next cycle carries the first bit of the frame on `sdo`. Samples are sent in slot order I0, Q0, then I1, Q1 when `dual_pair` is 1. Each sample is left-aligned in the word, and padding bits are zero. Word length follows `wlen_sel`: 00 gives 16 bits, 01 gives 24, and 10 or 11 give 32.
- R2: In each control word, the first bit received is READ (bit 15) and the second is WRITE (bit 14). Bits 10:8 are the register address and bits 7:0 the data byte. Bits 13:11, and every bit after the sixteenth, have no effect.
- R3: A word with READ=0 and WRITE=1 pulses `reg_wr` for one cycle, during the cycle that carries the word's sixteenth bit. `reg_addr` and `reg_wdata` are valid in that same cycle.
- R4: A word with READ=1 and WRITE=0 pulses `reg_rd` in the cycle of its sixteenth bit and captures `reg_rdata` in that cycle. The data byte of the word is ignored.
- R5: A frame accepts at most 2 reads for 16-bit words, 3 for 24-bit words and 4 for 32-bit words. Reads beyond that limit raise no `reg_rd` and leave no trace in the readback word.
- R6: In the readback word, the first read of the frame fills the most significant byte, and later reads fill the following bytes in arrival order. Byte lanes that no read filled are zero.
- R7: The readback word follows the sample words whenever the sample-word slots produced at least one read, or whenever `append_rb` was high when the frame opened. `frame_end` is high for exactly the one cycle that follows the last bit of the frame.
- R8: A word with READ and WRITE both set causes no register access. It sets `cmd_err`, which then stays high until reset.
- R9: The control word that arrives during the readback slot may perform a write and may set `cmd_err`, but it never performs a read.
- R10: Outside a frame, `sdo` is 0 and `sdi` causes no register access. Changes to `wlen_sel`, `dual_pair` and `append_rb` after a frame has opened do not affect that frame.
- R11: After reset, `sdo`, `frame_end`, `reg_rd`, `reg_wr` and `cmd_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst | input | 1 | Synchronous active-high reset |
| fsync | input | 1 | Frame sync; a rising edge opens a frame |
| sdi | input | 1 | Serial control input |
| sdo | output | 1 | Serial data output, MSB first |
| frame_end | output | 1 | One-cycle strobe after the last bit of the frame |
| append_rb | input | 1 | Forces the readback word into every frame |
| dual_pair | input | 1 | 1 selects two I/Q pairs per frame |
| wlen_sel | input | 2 | Word length select |
| i0 | input | SAMP_W | First-pair I sample |
| q0 | input | SAMP_W | First-pair Q sample |
| i1 | input | SAMP_W | Second-pair I sample |
| q1 | input | SAMP_W | Second-pair Q sample |
| reg_rd | output | 1 | Register read strobe |
| reg_wr | output | 1 | Register write strobe |
| reg_addr | output | 3 | Register address |
| reg_wdata | output | 8 | Register write data |
| reg_rdata | input | 8 | Register read data, sampled in the read cycle |
| cmd_err | output | 1 | Sticky flag for a word with both READ and WRITE set |

## Verification
The bench pushes the read count past its limit at each word length. A design with the wrong limit would either emit extra `reg_rd` pulses or drop reads it should keep, and the readback bytes would shift out of place. It also places reads and writes in the readback slot, and changes the frame configuration after a frame has opened. A design that decided the readback slot late, or latched the settings again mid-frame, would send the wrong number of words or bits. Forced append with no reads must produce an all-zero extra word and a late `frame_end`. The bench sets the ignored bits of every word to one and toggles `sdi` while idle, so any decoder that reads past the sixteenth bit or listens outside a frame would corrupt the external registers.

// File: rtl/scf_pkg.sv
package scf_pkg;
    localparam int WORD_MAX  = 32;
    localparam int CMD_BITS  = 16;
    localparam int ADDR_W    = 3;
    localparam int DATA_W    = 8;
    localparam int LANES     = WORD_MAX / DATA_W;
    localparam int BIT_W     = $clog2(WORD_MAX);
    localparam int SLOT_W    = 3;
    localparam int CNT_W     = $clog2(LANES + 1);

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2,
        OP_CLASH = 2'd3
    } op_e;

    typedef struct packed {
        op_e               op;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } cmd_t;

    function automatic logic [5:0] word_bits(input logic [1:0] sel);
        case (sel)
            2'b00:   return 6'd16;
            2'b01:   return 6'd24;
            default: return 6'd32;
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] read_cap(input logic [1:0] sel);
        case (sel)
            2'b00:   return CNT_W'(2);
            2'b01:   return CNT_W'(3);
            default: return CNT_W'(4);
        endcase
    endfunction
endpackage

// File: rtl/scf_cmd_decode.sv
module scf_cmd_decode
    import scf_pkg::*;
(
    input  logic [CMD_BITS-1:0] word,
    output cmd_t                cmd
);
    logic unused_pad;
    assign unused_pad = ^word[13:11];

    always_comb begin
        case ({word[15], word[14]})
            2'b10:   cmd.op = OP_READ;
            2'b01:   cmd.op = OP_WRITE;
            2'b11:   cmd.op = OP_CLASH;
            default: cmd.op = OP_NONE;
        endcase
        cmd.addr = word[10:8];
        cmd.data = word[7:0];
    end
endmodule

// File: rtl/scf_readback.sv
module scf_readback
    import scf_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                clr,
    input  logic                capture,
    input  logic [DATA_W-1:0]   byte_in,
    output logic [CNT_W-1:0]    count,
    output logic [WORD_MAX-1:0] rb_word
);
    always_ff @(posedge clk) begin
        if (rst || clr)   count <= '0;
        else if (capture) count <= count + CNT_W'(1);
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [DATA_W-1:0] lane_q;
        always_ff @(posedge clk) begin
            if (rst || clr)                           lane_q <= '0;
            else if (capture && count == CNT_W'(g))   lane_q <= byte_in;
        end
        assign rb_word[WORD_MAX-1-DATA_W*g -: DATA_W] = lane_q;
    end
endmodule

// File: rtl/scf_word_mux.sv
module scf_word_mux
    import scf_pkg::*;
#(
    parameter int SAMP_W = 16
) (
    input  logic [3:0][SAMP_W-1:0] samp,
    input  logic [WORD_MAX-1:0]    rb_word,
    input  logic [SLOT_W-1:0]      slot,
    input  logic [SLOT_W-1:0]      n_iq,
    output logic [WORD_MAX-1:0]    word
);
    localparam int PAD = WORD_MAX - SAMP_W;

    always_comb begin
        if (slot == n_iq) word = rb_word;
        else              word = WORD_MAX'(samp[slot[1:0]]) << PAD;
    end
endmodule

// File: rtl/ser_ctrl_frame.sv
module ser_ctrl_frame
    import scf_pkg::*;
#(
    parameter int SAMP_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fsync,
    input  logic              sdi,
    output logic              sdo,
    output logic              frame_end,
    input  logic              append_rb,
    input  logic              dual_pair,
    input  logic [1:0]        wlen_sel,
    input  logic [SAMP_W-1:0] i0,
    input  logic [SAMP_W-1:0] q0,
    input  logic [SAMP_W-1:0] i1,
    input  logic [SAMP_W-1:0] q1,
    output logic              reg_rd,
    output logic              reg_wr,
    output logic [2:0]        reg_addr,
    output logic [7:0]        reg_wdata,
    input  logic [7:0]        reg_rdata,
    output logic              cmd_err
);
    localparam int SR_W = CMD_BITS - 1;

    logic                   fsync_q, fs_rise, active;
    logic [BIT_W-1:0]       bit_idx;
    logic [SLOT_W-1:0]      slot, n_iq;
    logic [1:0]             wsel_q;
    logic                   dual_q, app_q, err_q, fe_q;
    logic [3:0][SAMP_W-1:0] samp_q;
    logic [SR_W-1:0]        in_sr;
    logic [5:0]             last_bit;
    logic                   rb_slot, cmd_done, word_done, rd_go, wr_go, send_rb;
    logic [CNT_W-1:0]       rd_cnt, rd_cnt_next;
    logic [WORD_MAX-1:0]    rb_word, cur_word;
    cmd_t                   cmd;

    assign fs_rise   = fsync & ~fsync_q;
    assign last_bit  = word_bits(wsel_q) - 6'd1;
    assign n_iq      = dual_q ? SLOT_W'(4) : SLOT_W'(2);
    assign rb_slot   = (slot == n_iq);
    assign cmd_done  = active && !fs_rise && (bit_idx == BIT_W'(CMD_BITS - 1));
    assign word_done = active && ({1'b0, bit_idx} == last_bit);

    scf_cmd_decode u_dec (
        .word ({in_sr, sdi}),
        .cmd  (cmd)
    );

    assign rd_go       = cmd_done && cmd.op == OP_READ && !rb_slot && rd_cnt < read_cap(wsel_q);
    assign wr_go       = cmd_done && cmd.op == OP_WRITE;
    assign rd_cnt_next = rd_cnt + CNT_W'(rd_go);
    assign send_rb     = app_q || (rd_cnt_next != '0);

    scf_readback u_rb (
        .clk     (clk),
        .rst     (rst),
        .clr     (fs_rise),
        .capture (rd_go),
        .byte_in (reg_rdata),
        .count   (rd_cnt),
        .rb_word (rb_word)
    );

    scf_word_mux #(.SAMP_W(SAMP_W)) u_mux (
        .samp    (samp_q),
        .rb_word (rb_word),
        .slot    (slot),
        .n_iq    (n_iq),
        .word    (cur_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            fsync_q <= 1'b0;
            active  <= 1'b0;
            bit_idx <= '0;
            slot    <= '0;
            wsel_q  <= 2'b00;
            dual_q  <= 1'b0;
            app_q   <= 1'b0;
            samp_q  <= '0;
            in_sr   <= '0;
            err_q   <= 1'b0;
            fe_q    <= 1'b0;
        end else begin
            fsync_q <= fsync;
            fe_q    <= 1'b0;
            if (fs_rise) begin
                active  <= 1'b1;
                bit_idx <= '0;
                slot    <= '0;
                wsel_q  <= wlen_sel;
                dual_q  <= dual_pair;
                app_q   <= append_rb;
                samp_q  <= {q1, i1, q0, i0};
            end else if (active) begin
                if (bit_idx < BIT_W'(SR_W))
                    in_sr <= {in_sr[SR_W-2:0], sdi};
                if (cmd_done && cmd.op == OP_CLASH)
                    err_q <= 1'b1;
                if (word_done) begin
                    bit_idx <= '0;
                    if (rb_slot || (slot == n_iq - SLOT_W'(1) && !send_rb)) begin
                        active <= 1'b0;
                        fe_q   <= 1'b1;
                    end else begin
                        slot <= slot + SLOT_W'(1);
                    end
                end else begin
                    bit_idx <= bit_idx + BIT_W'(1);
                end
            end
        end
    end

    assign sdo       = active & cur_word[BIT_W'(WORD_MAX - 1) - bit_idx];
    assign frame_end = fe_q;
    assign cmd_err   = err_q;
    assign reg_rd    = rd_go;
    assign reg_wr    = wr_go;
    assign reg_addr  = cmd.addr;
    assign reg_wdata = cmd.data;
endmodule

// File: rtl/ser_ctrl_frame_chk.sv
module ser_ctrl_frame_chk
    import scf_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       fsync,
    input logic [1:0] wlen_sel,
    input logic       sdo,
    input logic       frame_end,
    input logic       reg_rd,
    input logic       reg_wr,
    input logic       cmd_err
);
    logic             fs_q, in_frame;
    logic [CNT_W-1:0] rd_seen, cap;

    always_ff @(posedge clk) begin
        if (rst) begin
            fs_q     <= 1'b0;
            in_frame <= 1'b0;
            rd_seen  <= '0;
            cap      <= '0;
        end else begin
            fs_q <= fsync;
            if (fsync && !fs_q) begin
                in_frame <= 1'b1;
                rd_seen  <= '0;
                cap      <= read_cap(wlen_sel);
            end else begin
                if (frame_end) in_frame <= 1'b0;
                if (reg_rd)    rd_seen  <= rd_seen + CNT_W'(1);
            end
        end
    end

    a_r3_one_access: assert property (@(posedge clk) disable iff (rst)
        !(reg_rd && reg_wr));

    a_r8_err_sticky: assert property (@(posedge clk) disable iff (rst)
        cmd_err |=> cmd_err);

    a_r7_end_pulse: assert property (@(posedge clk) disable iff (rst)
        frame_end |=> !frame_end);

    a_r5_read_cap: assert property (@(posedge clk) disable iff (rst)
        reg_rd |-> (rd_seen < cap));

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !in_frame |-> (!reg_rd && !reg_wr && !sdo));
endmodule

bind ser_ctrl_frame ser_ctrl_frame_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .fsync     (fsync),
    .wlen_sel  (wlen_sel),
    .sdo       (sdo),
    .frame_end (frame_end),
    .reg_rd    (reg_rd),
    .reg_wr    (reg_wr),
    .cmd_err   (cmd_err)
);

// File: tb/sim_ser_ctrl_frame.sv
module sim_ser_ctrl_frame;
    localparam int CLK_PERIOD = 10;
    localparam int SW = 16;

    typedef struct packed {
        logic [1:0]       wsel;
        logic             dual;
        logic             app;
        logic [0:5][15:0] cmds;
        logic [2:0]       nwords;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{2'b00, 1'b0, 1'b0, '{16'h2F12, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000}, 3'd2},
        '{2'b00, 1'b0, 1'b0, '{16'h43A5, 16'h8355, 16'h0000, 16'h0000, 16'h0000, 16'h0000}, 3'd3},
        '{2'b01, 1'b1, 1'b0, '{16'h8100, 16'h8255, 16'h8300, 16'h8400, 16'h8500, 16'h0000}, 3'd5},
        '{2'b10, 1'b1, 1'b1, '{16'h4011, 16'h4122, 16'h0000, 16'h0000, 16'h4633, 16'h0000}, 3'd5},
        '{2'b11, 1'b0, 1'b1, '{16'h8600, 16'h8000, 16'h4777, 16'h0000, 16'h0000, 16'h0000}, 3'd3},
        '{2'b00, 1'b1, 1'b0, '{16'hC2FF, 16'h8100, 16'h8200, 16'h8300, 16'h0000, 16'h0000}, 3'd5},
        '{2'b10, 1'b0, 1'b0, '{16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000}, 3'd2}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic fsync = 1'b0, sdi = 1'b0, append_rb = 1'b0, dual_pair = 1'b0;
    logic [1:0] wlen_sel = 2'b00;
    logic [SW-1:0] i0 = '0, q0 = '0, i1 = '0, q1 = '0;
    logic sdo, frame_end, reg_rd, reg_wr, cmd_err;
    logic [2:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;

    logic [7:0] ext_regs [8];
    logic [7:0] m_regs [8];
    logic reg_load = 1'b0;
    integer rd_pulses = 0;
    integer total = 0, bad = 0;
    logic exp_err = 1'b0;
    logic finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ser_ctrl_frame #(.SAMP_W(SW)) u0 (
        .clk(clk), .rst(rst), .fsync(fsync), .sdi(sdi), .sdo(sdo),
        .frame_end(frame_end), .append_rb(append_rb), .dual_pair(dual_pair),
        .wlen_sel(wlen_sel), .i0(i0), .q0(q0), .i1(i1), .q1(q1),
        .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmd_err(cmd_err)
    );

    always @(posedge clk) begin
        if (reg_load) begin
            for (int i = 0; i < 8; i++) ext_regs[i] <= 8'h30 + 8'(i * 7);
        end else if (reg_wr) begin
            ext_regs[reg_addr] <= reg_wdata;
        end
        if (reg_rd) rd_pulses <= rd_pulses + 1;
    end
    assign reg_rdata = ext_regs[reg_addr];

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int wl_of(input logic [1:0] s);
        return (s == 2'b00) ? 16 : (s == 2'b01) ? 24 : 32;
    endfunction

    task automatic run_frame(input vec_t v, input int idx, input logic swap_cfg);
        int wl, lim, n_iq, rd, expn, nbits, rd_before;
        logic [7:0] lane [4];
        logic [31:0] got [6];
        logic [31:0] expw, mask;
        logic [15:0] smp [4];
        logic [15:0] c;
        logic send;

        wl = wl_of(v.wsel);
        lim = (v.wsel == 2'b00) ? 2 : (v.wsel == 2'b01) ? 3 : 4;
        n_iq = v.dual ? 4 : 2;
        smp[0] = 16'hA001 ^ 16'(idx * 16'h1357);
        smp[1] = 16'h5C02 ^ 16'(idx * 16'h0B0B);
        smp[2] = 16'h9E03 ^ 16'(idx * 16'h2222);
        smp[3] = 16'h3704 ^ 16'(idx * 16'h0F1F);
        for (int k = 0; k < 6; k++) got[k] = '0;
        for (int k = 0; k < 4; k++) lane[k] = '0;

        // model of the requirements
        rd = 0;
        for (int k = 0; k < n_iq; k++) begin
            c = v.cmds[k];
            case ({c[15], c[14]})
                2'b10: if (rd < lim) begin lane[rd] = m_regs[c[10:8]]; rd++; end
                2'b01: m_regs[c[10:8]] = c[7:0];
                2'b11: exp_err = 1'b1;
                default: ;
            endcase
        end
        send = v.app || (rd > 0);
        expn = n_iq + (send ? 1 : 0);
        if (send) begin
            c = v.cmds[n_iq];
            if ({c[15], c[14]} == 2'b01) m_regs[c[10:8]] = c[7:0];
            if ({c[15], c[14]} == 2'b11) exp_err = 1'b1;
        end

        @(negedge clk);
        wlen_sel = v.wsel; dual_pair = v.dual; append_rb = v.app;
        i0 = smp[0]; q0 = smp[1]; i1 = smp[2]; q1 = smp[3];
        rd_before = rd_pulses;
        fsync = 1'b1;
        @(negedge clk);
        fsync = 1'b0;
        if (swap_cfg) begin
            wlen_sel = ~v.wsel; dual_pair = ~v.dual; append_rb = ~v.app;
            i0 = ~smp[0];
        end
        nbits = 0;
        for (int cyc = 0; cyc < 6 * 32 + 4; cyc++) begin
            if (frame_end) break;
            if (nbits < 6 * wl) begin
                got[nbits / wl] = got[nbits / wl] | (32'(sdo) << (31 - (nbits % wl)));
                sdi = ((nbits % wl) < 16) ? v.cmds[nbits / wl][15 - (nbits % wl)] : 1'b1;
            end
            nbits++;
            @(negedge clk);
        end
        sdi = 1'b0;

        chk(nbits == expn * wl, "R7 frame length in bits", 32'(nbits), 32'(expn * wl));
        chk(expn == int'(v.nwords), "R7 table word count", 32'(expn), 32'(v.nwords));
        mask = ~(32'hFFFF_FFFF >> wl);
        for (int k = 0; k < expn; k++) begin
            if (k < n_iq) begin
                expw = {smp[k], 16'h0000} & mask;
                chk(got[k] == expw, "R1 sample word", got[k], expw);
            end else begin
                expw = {lane[0], lane[1], lane[2], lane[3]} & mask;
                chk(got[k] == expw, "R6 readback word", got[k], expw);
            end
        end
        chk((rd_pulses - rd_before) == rd, "R5 R9 read strobe count", 32'(rd_pulses - rd_before), 32'(rd));
        chk(cmd_err == exp_err, "R8 error flag", 32'(cmd_err), 32'(exp_err));
        for (int k = 0; k < 8; k++)
            chk(ext_regs[k] == m_regs[k], "R3 R2 register contents", 32'(ext_regs[k]), 32'(m_regs[k]));
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        vec_t sv;
        int viol;
        for (int i = 0; i < 8; i++) m_regs[i] = 8'h30 + 8'(i * 7);
        reg_load = 1'b1;
        repeat (3) @(negedge clk);
        reg_load = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk(sdo == 1'b0, "R11 sdo after reset", 32'(sdo), 0);
        chk(frame_end == 1'b0, "R11 frame_end after reset", 32'(frame_end), 0);
        chk(cmd_err == 1'b0, "R11 cmd_err after reset", 32'(cmd_err), 0);
        chk(!reg_rd && !reg_wr, "R11 strobes after reset", {30'b0, reg_rd, reg_wr}, 0);

        // vector table: R1..R9
        for (int v = 0; v < 7; v++) begin
            run_frame(VECS[v], v, 1'b0);
            repeat (2) @(negedge clk);
        end

        // R10 configuration changed after frame opens has no effect
        sv = '{2'b00, 1'b0, 1'b0, '{16'h4255, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000}, 3'd2};
        run_frame(sv, 9, 1'b1);
        repeat (2) @(negedge clk);

        // R4 read sees a write made earlier in the same frame, in a 32-bit frame
        sv = '{2'b10, 1'b1, 1'b0, '{16'h4599, 16'h8500, 16'h8000, 16'hC000, 16'h8700, 16'h0000}, 3'd5};
        run_frame(sv, 10, 1'b0);
        repeat (2) @(negedge clk);

        // R10 idle: sdi toggling outside a frame must not access registers
        viol = 0;
        for (int k = 0; k < 48; k++) begin
            sdi = (16'h47EE >> (15 - (k % 16))) & 1'b1;
            if (reg_rd || reg_wr || sdo) viol++;
            @(negedge clk);
        end
        sdi = 1'b0;
        chk(viol == 0, "R10 idle quiet", 32'(viol), 0);
        for (int k = 0; k < 8; k++)
            chk(ext_regs[k] == m_regs[k], "R10 idle registers unchanged", 32'(ext_regs[k]), 32'(m_regs[k]));

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule